// File: doc/BRIEF.md
# Command-Controlled UART Receive Channel

This block is the receive half of a serial port. A start-bit hunter and a shift register recover 8-bit characters from an asynchronous serial line. The line is oversampled at sixteen ticks per bit, and the ticks are supplied as a clock-enable. Each character that is completed is written into a small holding FIFO. A bus-side read strobe removes the oldest character and places it on a registered data output. The outputs are a ready flag, which says that characters are waiting, and a sticky overrun flag. The overrun flag is cleared only by its own error-reset strobe.

A 2-bit command, qualified by a valid strobe, switches the receiver on and off. Switching it on restarts the hunt for a start bit. Switching it off stops reception at once and discards the partly shifted character. Switching it off does not touch the FIFO contents or the status flags. Two mode inputs stand for the echo-test (loop-back) mode and the shared-line (multidrop) mode. While either mode input is high, the receiver keeps running whatever the command state is.

Top module: `uart_rx_chan`

## Requirements
- R1: After reset, `rd_data` is 0x00, `rx_ready` and `overrun` are 0, and the receiver is switched off, so a frame sent before any enable command stores nothing.
- R2: A frame is one low start bit, 8 data bits sent least significant bit first, and one high stop bit, each bit lasting 16 `tick16` pulses. Each such frame yields its byte at `rd_data` when it is read.
- R3: A start bit is accepted only if the line is still low at the 8th tick after the falling edge was seen. A shorter low pulse is ignored and the receiver returns to the search.
- R4: The FIFO holds up to three characters. A read pulse on `rd_en` pops the oldest character, and it appears on `rd_data` one clock later.
- R5: `rx_ready` is high exactly when at least one character is held.
- R6: If a character completes while three characters are held and no read occurs in that cycle, the new character is dropped, `overrun` goes to 1, and the held characters are kept.
- R7: `overrun` stays at 1 until `clr_err` is pulsed. A disable command does not clear it.
- R8: Command codes, applied when `cmd_valid` is high, are: 2'b01 enable, 2'b10 disable, 2'b00 no action. Code 2'b11 is also treated as no action.
- R9: A disable command takes effect on the next clock. It discards any character being received and leaves the FIFO, `rx_ready` and `overrun` unchanged.
- R10: While `loopback_mode` or `multidrop_mode` is high, characters are received even after a disable command.
- R11: An enable command given to a receiver that is already on has no effect, so a frame already in progress still completes.
- R12: A frame whose stop bit samples low is discarded.
- R13: A read pulse while the FIFO is empty leaves `rd_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| cmd_valid | input | 1 | Qualifies `cmd` for one cycle |
| cmd | input | 2 | Receiver command code |
| loopback_mode | input | 1 | Loop-back mode select; keeps the receiver running |
| multidrop_mode | input | 1 | Multidrop mode select; keeps the receiver running |
| rd_en | input | 1 | Pops the oldest held character |
| clr_err | input | 1 | Clears the overrun flag |
| rd_data | output | 8 | Last character read; resets to 0x00 |
| rx_ready | output | 1 | At least one character is held |
| overrun | output | 1 | Sticky flag for a dropped character |

## Verification
The assertions check the following on every cycle:
- the FIFO never holds more than its depth, and the ready flag follows the fill level;
- a push into a full FIFO with no read raises the overrun flag, and the flag holds until the clear strobe;
- a disable command switches the receiver off by the next clock;
- the shifter is idle whenever the receiver is not running;
- an empty read leaves the data output unchanged.

Only the bench scenarios can show the rest:
- the serial framing, with data arriving least significant bit first;
- the rejection of short start glitches and of bad stop bits;
- the order in which the FIFO returns characters;
- the loss of a character aborted mid-frame;
- the survival of a frame across a redundant enable command;
- the override of the disable command by the two mode inputs.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_EN  = 2'b01,
    CMD_DIS = 2'b10,
    CMD_RSV = 2'b11
  } rx_cmd_t;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_START = 2'b01,
    S_DATA  = 2'b10,
    S_STOP  = 2'b11
  } rx_state_t;
endpackage

// File: rtl/rx_cmd_ctrl.sv
module rx_cmd_ctrl
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_valid,
  input  logic [1:0] cmd,
  input  logic       loopback_mode,
  input  logic       multidrop_mode,
  output logic       run,
  output logic       restart
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      restart <= 1'b0;
    end else begin
      restart <= 1'b0;
      if (cmd_valid) begin
        case (rx_cmd_t'(cmd))
          CMD_EN: if (!en_q) begin
            en_q    <= 1'b1;
            restart <= 1'b1;
          end
          CMD_DIS: en_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign run = en_q | loopback_mode | multidrop_mode;

  // R9: a disable command switches the receiver off on the next clock
  assert_disable_takes_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_DIS) |=> !en_q);
  // R11: an enable command given while already on does not restart the search
  assert_no_redundant_restart_R11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd == CMD_EN && en_q) |=> !restart);
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              restart,
  input  logic              tick16,
  input  logic              rxd,
  output logic              done,
  output logic [DATA_W-1:0] char_out
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR / 2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] TOPB = BIT_W'(DATA_W - 1);

  rx_state_t         state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [DATA_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      sr    <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run || restart) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else if (tick16) begin
        case (state)
          S_IDLE: if (!rxd) begin
            state <= S_START;
            cnt   <= '0;
          end
          S_START: begin
            cnt <= cnt + 1'b1;
            if (cnt == MID) begin
              cnt   <= '0;
              bitn  <= '0;
              state <= rxd ? S_IDLE : S_DATA;
            end
          end
          S_DATA: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              sr <= {rxd, sr[DATA_W-1:1]};
              bitn <= bitn + 1'b1;
              if (bitn == TOPB) state <= S_STOP;
            end
          end
          S_STOP: begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              done  <= rxd;
              state <= S_IDLE;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign char_out = sr;

  // R9/R10: the shifter is idle whenever the receiver is not running
  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (rst)
    !run |=> state == S_IDLE);
  // R12: a character is only reported from the stop-bit phase
  assert_done_from_stop_R12: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(state) == S_STOP);
endmodule

// File: rtl/rx_hold_fifo.sv
module rx_hold_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              overrun
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wp, rp;
  logic [CNT_W-1:0]  count;
  logic              full, empty, do_pop, do_push;
  logic [CNT_W-1:0]  count_nxt;

  assign full    = (count == CNT_FULL);
  assign empty   = (count == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);

  always_comb begin
    count_nxt = count;
    if (do_push && !do_pop) count_nxt = count + 1'b1;
    if (!do_push && do_pop) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      rd_data  <= '0;
      rx_ready <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      count    <= count_nxt;
      rx_ready <= (count_nxt != '0);
      if (do_push) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
      if (do_pop) begin
        rd_data <= mem[rp];
        rp      <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
      end
      if (clr_err) overrun <= 1'b0;
      else if (push && !do_push) overrun <= 1'b1;
    end
  end

  // R4: the FIFO never holds more than its depth
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_FULL);
  // R5: the ready flag follows the fill level
  assert_ready_level_R5: assert property (@(posedge clk) disable iff (rst)
    rx_ready == (count != '0));
  // R6: a push into a full FIFO with no read raises overrun
  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop && !clr_err) |=> overrun);
  // R7: overrun holds until the clear strobe
  assert_overrun_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (overrun && !clr_err) |=> overrun);
  // R13: a read from an empty FIFO leaves the data output unchanged
  assert_empty_read_R13: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> $stable(rd_data));
endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick16,
  input  logic              rxd,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd,
  input  logic              loopback_mode,
  input  logic              multidrop_mode,
  input  logic              rd_en,
  input  logic              clr_err,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_ready,
  output logic              overrun
);
  logic              run, restart, done;
  logic [DATA_W-1:0] char_out;

  rx_cmd_ctrl u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd(cmd),
    .loopback_mode(loopback_mode), .multidrop_mode(multidrop_mode),
    .run(run), .restart(restart)
  );

  rx_shifter #(.DATA_W(DATA_W), .OSR(OSR)) u_shift (
    .clk(clk), .rst(rst), .run(run), .restart(restart), .tick16(tick16),
    .rxd(rxd), .done(done), .char_out(char_out)
  );

  rx_hold_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(done), .push_data(char_out), .pop(rd_en),
    .clr_err(clr_err), .rd_data(rd_data), .rx_ready(rx_ready), .overrun(overrun)
  );
endmodule

// File: tb/sim_uart_rx_chan.sv
module sim_uart_rx_chan;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick16 = 1'b1;
  logic       rxd = 1'b1;
  logic       cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       loopback_mode = 1'b0;
  logic       multidrop_mode = 1'b0;
  logic       rd_en = 1'b0;
  logic       clr_err = 1'b0;
  logic [7:0] rd_data;
  logic       rx_ready, overrun;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] expq[$];

  always #2 clk = ~clk;

  uart_rx_chan u0 (
    .clk(clk), .rst(rst), .tick16(tick16), .rxd(rxd), .cmd_valid(cmd_valid),
    .cmd(cmd), .loopback_mode(loopback_mode), .multidrop_mode(multidrop_mode),
    .rd_en(rd_en), .clr_err(clr_err), .rd_data(rd_data), .rx_ready(rx_ready),
    .overrun(overrun)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic command(input logic [1:0] c);
    @(negedge clk); cmd_valid = 1'b1; cmd = c;
    @(negedge clk); cmd_valid = 1'b0; cmd = 2'b00;
  endtask

  // Driver: sends one frame; optionally issues a command at cycle 'at';
  // pushes the byte into the scoreboard when it is expected to be stored.
  task automatic send(input logic [7:0] d, input logic stopb, input int at,
                      input logic [1:0] c, input bit expect_it);
    for (int i = 0; i < 176; i++) begin
      @(negedge clk);
      if (i < 16)       rxd = 1'b0;
      else if (i < 144) rxd = d[(i - 16) / 16];
      else if (i < 160) rxd = stopb;
      else              rxd = 1'b1;
      cmd_valid = (i == at);
      cmd = (i == at) ? c : 2'b00;
    end
    @(negedge clk); cmd_valid = 1'b0; rxd = 1'b1;
    if (expect_it) expq.push_back(d);
  endtask

  // Monitor: pops one character and compares it with the scoreboard head.
  task automatic read_cmp(input string req);
    logic [7:0] e;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    if (expq.size() == 0) begin
      checks++; errors++;
      $display("FAIL %s: actual=%0h expected=<none>", req, rd_data);
    end else begin
      e = expq.pop_front();
      check(req, rd_data, e);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<150000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] hold;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 rx_ready", rx_ready, 0);
    check("R1 overrun", overrun, 0);
    send(8'hA5, 1'b1, -1, 2'b00, 0);
    check("R1 off after reset", rx_ready, 0);
    command(2'b11);
    send(8'h5A, 1'b1, -1, 2'b00, 0);
    check("R8 reserved is no action", rx_ready, 0);
    command(2'b01);
    send(8'hA5, 1'b1, -1, 2'b00, 1);
    check("R5 ready set", rx_ready, 1);
    read_cmp("R2 byte A5");
    check("R5 ready cleared", rx_ready, 0);
    // R3: short start glitch
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    check("R3 glitch ignored", rx_ready, 0);
    send(8'h3C, 1'b1, -1, 2'b00, 1);
    read_cmp("R3 search resumes");
    // R4/R6: fill and overrun
    send(8'h01, 1'b1, -1, 2'b00, 1);
    send(8'h80, 1'b1, -1, 2'b00, 1);
    send(8'hC3, 1'b1, -1, 2'b00, 1);
    check("R6 no overrun at three", overrun, 0);
    send(8'hFF, 1'b1, -1, 2'b00, 0);
    check("R6 overrun set", overrun, 1);
    read_cmp("R4 oldest first");
    read_cmp("R4 second");
    read_cmp("R6 held kept");
    check("R5 empty", rx_ready, 0);
    hold = rd_data;
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
    check("R13 empty read", rd_data, hold);
    command(2'b10);
    check("R7 disable keeps overrun", overrun, 1);
    @(negedge clk); clr_err = 1'b1;
    @(negedge clk); clr_err = 1'b0;
    check("R7 cleared", overrun, 0);
    send(8'h77, 1'b1, -1, 2'b00, 0);
    check("R9 disabled ignores", rx_ready, 0);
    // R9: abort mid-frame while one character is held
    command(2'b01);
    send(8'h11, 1'b1, -1, 2'b00, 1);
    send(8'h22, 1'b1, 60, 2'b10, 0);
    check("R9 ready kept", rx_ready, 1);
    read_cmp("R9 FIFO kept");
    check("R9 aborted char dropped", rx_ready, 0);
    command(2'b01);
    send(8'h4B, 1'b1, 60, 2'b01, 1);
    read_cmp("R11 redundant enable");
    send(8'hD2, 1'b1, 60, 2'b00, 1);
    read_cmp("R8 no-action mid frame");
    send(8'h99, 1'b0, -1, 2'b00, 0);
    check("R12 bad stop dropped", rx_ready, 0);
    loopback_mode = 1'b1;
    command(2'b10);
    send(8'h6E, 1'b1, -1, 2'b00, 1);
    read_cmp("R10 loopback overrides");
    loopback_mode = 1'b0;
    multidrop_mode = 1'b1;
    send(8'h93, 1'b1, 60, 2'b10, 1);
    read_cmp("R10 multidrop overrides");
    multidrop_mode = 1'b0;
    send(8'h44, 1'b1, -1, 2'b00, 0);
    check("R10 off once modes drop", rx_ready, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule